// File: doc/BRIEF.md
# Two-Level Instruction Control Decoder

This block is the purely combinational control unit for a small single-cycle 32-bit load/store processor. It reads the 6-bit primary opcode and the 6-bit function field of the current instruction. From these it produces the strobes that steer the datapath: the register-write enable, the memory read and write enables, the branch qualifier, and the three multiplexer selects for the destination register, the second ALU operand and the write-back source. It also produces the 4-bit code that chooses the ALU operation.

The work is split into two levels. The first level looks only at the opcode. It produces the datapath strobes and a 2-bit ALU class code, where 00 means address add, 01 means compare-by-subtract and 10 means the function field decides. The second level never sees the opcode. It combines the class code with the function field to produce the ALU operation code. The class code is also exported, so that neighbouring logic can observe it.

A parameter chooses how the second level is built. The default is a set of reduced sum-of-products equations; the alternative is an explicit lookup. On every specified code the two agree.

Top module: `instrCtrlDecoder`

## Requirements
- R1: Opcode 0x00 (register-register) gives regDst=1, aluSrc=0, memToReg=0, regWrite=1, memRead=0, memWrite=0, branch=0 and aluOp=10.
- R2: Opcode 0x23 (load word) gives regDst=0, aluSrc=1, memToReg=1, regWrite=1, memRead=1, memWrite=0, branch=0 and aluOp=00.
- R3: Opcode 0x2B (store word) gives aluSrc=1, memWrite=1, aluOp=00, and drives regDst, memToReg, regWrite, memRead and branch to 0.
- R4: Opcode 0x04 (branch if equal) gives branch=1, aluOp=01, and drives regDst, aluSrc, memToReg, regWrite, memRead and memWrite to 0.
- R5: Any other opcode drives all seven strobes to 0 and aluOp to 00.
- R6: When aluOp is 00, aluCtrl is 0010 (add) whatever the function field holds.
- R7: When aluOp is 01, aluCtrl is 0110 (subtract) whatever the function field holds.
- R8: When aluOp is 10, the function field selects the operation: 0x20 gives 0010 (add), 0x22 gives 0110 (subtract), 0x24 gives 0000 (and), 0x25 gives 0001 (or), and 0x2A gives 0111 (set-on-less-than).
- R9: aluCtrl bit 3 is 0 for every input.
- R10: memRead and memWrite are never both 1. branch is never 1 together with regWrite or memWrite.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode, instruction bits 31:26 |
| funct | input | 6 | Function field, instruction bits 5:0 |
| regDst | output | 1 | 1 selects bits 15:11 as destination register, 0 selects bits 20:16 |
| aluSrc | output | 1 | 1 selects the sign-extended immediate as second ALU operand |
| memToReg | output | 1 | 1 writes back memory read data, 0 writes back the ALU result |
| regWrite | output | 1 | Register file write enable |
| memRead | output | 1 | Data memory read enable |
| memWrite | output | 1 | Data memory write enable |
| branch | output | 1 | Instruction is a conditional branch; the datapath ANDs it with the zero flag |
| aluOp | output | 2 | Intermediate ALU class code |
| aluCtrl | output | 4 | ALU operation code |

## Verification
The bench sweeps all 64 opcodes. For each opcode it applies several function fields, and these include values that look like valid R-type codes. A decoder that let the function field leak into load, store or branch decoding would then show a wrong aluCtrl under R6 or R7. The unused opcodes are checked to be inert. A design that matched on only a few opcode bits would alias some of them onto load or store, and that would raise memory or register strobes. Each of the five R-type function codes is checked on its own. This catches any swapped equation term, in particular an inverted F[2] term, which would confuse and/or with add/sub.

// File: rtl/instrCtrlPkg.sv
package instrCtrlPkg;

  localparam int OPCODE_W  = 6;
  localparam int FUNCT_W   = 6;
  localparam int ALU_OP_W  = 2;
  localparam int ALU_SEL_W = 4;

  // ALU class code passed from the first level to the second
  typedef enum logic [ALU_OP_W-1:0] {
    CLASS_ADDR = 2'b00,
    CLASS_CMP  = 2'b01,
    CLASS_FUNC = 2'b10,
    CLASS_RSVD = 2'b11
  } aluClass_t;

  // strobes handed from the control level to the datapath-facing outputs
  typedef struct packed {
    logic regDst;
    logic aluSrc;
    logic memToReg;
    logic regWrite;
    logic memRead;
    logic memWrite;
    logic branch;
  } ctrlStrobes_t;

  localparam ctrlStrobes_t STROBES_IDLE = '0;

endpackage

// File: rtl/mainDecoder.sv
module mainDecoder
  import instrCtrlPkg::*;
#(
  parameter int                 OP_W     = OPCODE_W,
  parameter logic [OP_W-1:0]    OP_RTYPE = 6'h00,
  parameter logic [OP_W-1:0]    OP_LOAD  = 6'h23,
  parameter logic [OP_W-1:0]    OP_STORE = 6'h2B,
  parameter logic [OP_W-1:0]    OP_BEQ   = 6'h04
) (
  input  logic [OP_W-1:0] opcode,
  output ctrlStrobes_t    strobes,
  output aluClass_t       aluClass
);

  always_comb begin
    strobes  = STROBES_IDLE;
    aluClass = CLASS_ADDR;
    unique case (opcode)
      OP_RTYPE: begin
        strobes.regDst   = 1'b1;
        strobes.regWrite = 1'b1;
        aluClass         = CLASS_FUNC;
      end
      OP_LOAD: begin
        strobes.aluSrc   = 1'b1;
        strobes.memToReg = 1'b1;
        strobes.regWrite = 1'b1;
        strobes.memRead  = 1'b1;
        aluClass         = CLASS_ADDR;
      end
      OP_STORE: begin
        strobes.aluSrc   = 1'b1;
        strobes.memWrite = 1'b1;
        aluClass         = CLASS_ADDR;
      end
      OP_BEQ: begin
        strobes.branch   = 1'b1;
        aluClass         = CLASS_CMP;
      end
      default: begin
        strobes  = STROBES_IDLE;
        aluClass = CLASS_ADDR;
      end
    endcase
  end

endmodule

// File: rtl/aluDecoder.sv
module aluDecoder
  import instrCtrlPkg::*;
#(
  parameter int FN_W      = FUNCT_W,
  parameter int SEL_W     = ALU_SEL_W,
  parameter bit USE_TABLE = 1'b0
) (
  input  aluClass_t         aluClass,
  input  logic [FN_W-1:0]   funct,
  output logic [SEL_W-1:0]  aluSel
);

  localparam logic [SEL_W-1:0] SEL_AND = SEL_W'(4'b0000);
  localparam logic [SEL_W-1:0] SEL_OR  = SEL_W'(4'b0001);
  localparam logic [SEL_W-1:0] SEL_ADD = SEL_W'(4'b0010);
  localparam logic [SEL_W-1:0] SEL_SUB = SEL_W'(4'b0110);
  localparam logic [SEL_W-1:0] SEL_SLT = SEL_W'(4'b0111);

  logic classHi;
  logic classLo;
  assign classHi = aluClass[1];
  assign classLo = aluClass[0];

  generate
    if (USE_TABLE) begin : gTable
      always_comb begin
        unique case (aluClass)
          CLASS_ADDR: aluSel = SEL_ADD;
          CLASS_CMP:  aluSel = SEL_SUB;
          default: begin
            unique case (funct)
              FN_W'(6'h20): aluSel = SEL_ADD;
              FN_W'(6'h22): aluSel = SEL_SUB;
              FN_W'(6'h24): aluSel = SEL_AND;
              FN_W'(6'h25): aluSel = SEL_OR;
              FN_W'(6'h2A): aluSel = SEL_SLT;
              default:      aluSel = SEL_ADD;
            endcase
          end
        endcase
      end
    end else begin : gEquations
      logic [3:0] eqSel;
      always_comb begin
        eqSel[3] = 1'b0;
        eqSel[2] = classLo | (classHi & funct[1]);
        eqSel[1] = ~classHi | ~funct[2];
        eqSel[0] = classHi & (funct[3] | funct[0]);
      end
      if (SEL_W > 4) begin : gPad
        assign aluSel = {{(SEL_W-4){1'b0}}, eqSel};
      end else begin : gNoPad
        assign aluSel = eqSel[SEL_W-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/instrCtrlDecoder.sv
module instrCtrlDecoder
  import instrCtrlPkg::*;
#(
  parameter bit ALU_USE_TABLE = 1'b0
) (
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output logic       regDst,
  output logic       aluSrc,
  output logic       memToReg,
  output logic       regWrite,
  output logic       memRead,
  output logic       memWrite,
  output logic       branch,
  output logic [1:0] aluOp,
  output logic [3:0] aluCtrl
);

  ctrlStrobes_t strobes;
  aluClass_t    aluClass;

  mainDecoder uMain (
    .opcode   (opcode),
    .strobes  (strobes),
    .aluClass (aluClass)
  );

  aluDecoder #(.USE_TABLE(ALU_USE_TABLE)) uAlu (
    .aluClass (aluClass),
    .funct    (funct),
    .aluSel   (aluCtrl)
  );

  assign regDst   = strobes.regDst;
  assign aluSrc   = strobes.aluSrc;
  assign memToReg = strobes.memToReg;
  assign regWrite = strobes.regWrite;
  assign memRead  = strobes.memRead;
  assign memWrite = strobes.memWrite;
  assign branch   = strobes.branch;
  assign aluOp    = aluClass;

endmodule

// File: rtl/instrCtrlChecker.sv
module instrCtrlChecker (
  input logic [5:0] opcode,
  input logic [5:0] funct,
  input logic       regDst,
  input logic       aluSrc,
  input logic       memToReg,
  input logic       regWrite,
  input logic       memRead,
  input logic       memWrite,
  input logic       branch,
  input logic [1:0] aluOp,
  input logic [3:0] aluCtrl
);

  always_comb begin
    if (!$isunknown({opcode, funct})) begin
      if (opcode == 6'h00)
        assert_rtype_strobes_R1: assert ({regDst, aluSrc, memToReg, regWrite, memRead, memWrite, branch, aluOp} == 9'b1_0_0_1_0_0_0_10);
      if (opcode == 6'h23)
        assert_load_strobes_R2: assert ({regDst, aluSrc, memToReg, regWrite, memRead, memWrite, branch, aluOp} == 9'b0_1_1_1_1_0_0_00);
      if (opcode == 6'h2B)
        assert_store_strobes_R3: assert ({aluSrc, regWrite, memRead, memWrite, branch, aluOp} == 7'b1_0_0_1_0_00);
      if (opcode == 6'h04)
        assert_beq_strobes_R4: assert ({aluSrc, regWrite, memRead, memWrite, branch, aluOp} == 7'b0_0_0_0_1_01);
      if (opcode != 6'h00 && opcode != 6'h23 && opcode != 6'h2B && opcode != 6'h04)
        assert_unknown_inert_R5: assert ({regWrite, memRead, memWrite, branch} == 4'b0000);
      if (aluOp == 2'b00)
        assert_addr_add_R6: assert (aluCtrl == 4'b0010);
      if (aluOp == 2'b01)
        assert_cmp_sub_R7: assert (aluCtrl == 4'b0110);
      if (opcode == 6'h00 && funct == 6'h2A)
        assert_slt_code_R8: assert (aluCtrl == 4'b0111);
      assert_sel_msb_zero_R9: assert (aluCtrl[3] == 1'b0);
      assert_mem_exclusive_R10: assert (!(memRead && memWrite));
      assert_branch_no_write_R10: assert (!(branch && (regWrite || memWrite)));
    end
  end

endmodule

bind instrCtrlDecoder instrCtrlChecker uChecker (
  .opcode   (opcode),
  .funct    (funct),
  .regDst   (regDst),
  .aluSrc   (aluSrc),
  .memToReg (memToReg),
  .regWrite (regWrite),
  .memRead  (memRead),
  .memWrite (memWrite),
  .branch   (branch),
  .aluOp    (aluOp),
  .aluCtrl  (aluCtrl)
);

// File: tb/tb_instrCtrlDecoder.sv
`timescale 1ns/1ps
module tb_instrCtrlDecoder;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct  = '0;
  logic       regDst, aluSrc, memToReg, regWrite, memRead, memWrite, branch;
  logic [1:0] aluOp;
  logic [3:0] aluCtrl;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int cycles = 0;

  instrCtrlDecoder dut (
    .opcode(opcode), .funct(funct),
    .regDst(regDst), .aluSrc(aluSrc), .memToReg(memToReg), .regWrite(regWrite),
    .memRead(memRead), .memWrite(memWrite), .branch(branch),
    .aluOp(aluOp), .aluCtrl(aluCtrl)
  );

  // behavioural reference: strobes {regDst,aluSrc,memToReg,regWrite,memRead,memWrite,branch}
  function automatic logic [6:0] refStrobes(input int op);
    case (op)
      'h00:    return 7'b1001000;
      'h23:    return 7'b0111100;
      'h2B:    return 7'b0100010;
      'h04:    return 7'b0000001;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic logic [1:0] refClass(input int op);
    if (op == 'h00) return 2'b10;
    if (op == 'h04) return 2'b01;
    return 2'b00;
  endfunction

  // returns -1 when the code is unspecified
  function automatic int refAlu(input int op, input int fn);
    if (op != 'h00) return (op == 'h04) ? 6 : 2;
    case (fn)
      'h20: return 2;
      'h22: return 6;
      'h24: return 0;
      'h25: return 1;
      'h2A: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic string tagFor(input int op);
    case (op)
      'h00: return "R1";
      'h23: return "R2";
      'h2B: return "R3";
      'h04: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic applyAndCheck(input int op, input int fn);
    logic [6:0] expS;
    logic [1:0] expC;
    int expA;
    @(posedge clk);
    #1;
    opcode = op[5:0];
    funct  = fn[5:0];
    @(negedge clk);
    expS = refStrobes(op);
    expC = refClass(op);
    expA = refAlu(op, fn);
    checks++;
    if ({regDst, aluSrc, memToReg, regWrite, memRead, memWrite, branch} !== expS ||
        aluOp !== expC) begin
      errors++;
      $display("FAIL %s op=%h fn=%h strobes/aluOp actual=%b/%b expected=%b/%b",
               tagFor(op), op[5:0], fn[5:0],
               {regDst, aluSrc, memToReg, regWrite, memRead, memWrite, branch}, aluOp, expS, expC);
    end
    if (expA >= 0) begin
      checks++;
      if (aluCtrl !== expA[3:0]) begin
        errors++;
        $display("FAIL %s op=%h fn=%h aluCtrl actual=%b expected=%b",
                 (op == 'h00) ? "R8" : ((op == 'h04) ? "R7" : "R6"),
                 op[5:0], fn[5:0], aluCtrl, expA[3:0]);
      end
    end
    checks++;   // R9 and R10 hold on every vector
    if (aluCtrl[3] !== 1'b0 || (memRead && memWrite) || (branch && (regWrite || memWrite))) begin
      errors++;
      $display("FAIL R9/R10 op=%h fn=%h actual ctrl=%b rd=%b wr=%b br=%b rw=%b expected msb=0 exclusive",
               op[5:0], fn[5:0], aluCtrl, memRead, memWrite, branch, regWrite);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle-state check with opcode 0x3F (unused), R5
    applyAndCheck('h3F, 'h00);
    // R1 and R8: each function code individually
    applyAndCheck('h00, 'h20);
    applyAndCheck('h00, 'h22);
    applyAndCheck('h00, 'h24);
    applyAndCheck('h00, 'h25);
    applyAndCheck('h00, 'h2A);
    // R2, R3 and R6: function field holding R-type-like codes must not matter
    applyAndCheck('h23, 'h24);
    applyAndCheck('h23, 'h2A);
    applyAndCheck('h2B, 'h25);
    applyAndCheck('h2B, 'h3F);
    // R4 and R7
    applyAndCheck('h04, 'h24);
    applyAndCheck('h04, 'h00);
    // exhaustive opcode sweep with several function fields, R5 included
    for (int op = 0; op < 64; op++) begin
      for (int k = 0; k < 6; k++) begin
        int fn;
        case (k)
          0: fn = 'h20;
          1: fn = 'h22;
          2: fn = 'h24;
          3: fn = 'h25;
          4: fn = 'h2A;
          default: fn = (op * 7 + 3) & 'h3F;
        endcase
        applyAndCheck(op, fn);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule